// File: doc/BRIEF.md
# Single-Cycle 16-bit Load/Store Processor

This block is a small processor that completes one instruction on every rising clock edge. Decoding is hardwired. The three register fields of the instruction word drive the register-file address lines directly. The opcode only selects the ALU function, the writeback source, the store strobe and the branch condition.

Instruction and data storage are separate, and both sit outside the block. Instruction memory is a read-only array with asynchronous read, addressed by the program counter. Data memory is read asynchronously and written on the clock edge while the write strobe is high. A copy of the PC is brought out for observation.

Top module: `sc16_cpu`

## Requirements
- R1: While `rst_ni` is low the PC is zero. Releasing reset leaves all eight registers at zero, so execution restarts from address 0 with cleared registers.
- R2: When no branch is taken, the PC rises by exactly one on each clock edge.
- R3: The instruction word is laid out as opcode [15:9], destination DR [8:6], source SA [5:3] and source SB [2:0]. The register-register forms write R[DR] <= R[SA] op R[SB]: ADD 0x01, SUB 0x02 (SA minus SB), AND 0x03, OR 0x04, XOR 0x05.
- R4: The single-source forms write R[DR] from R[SA]: MOV 0x00 (copy), NOT 0x06 (bitwise invert), SHL 0x07 (left by one, zero fill) and SHR 0x08 (logical right by one, zero fill).
- R5: The immediate forms use bits [2:0] zero-extended to 16 bits. ADI 0x09 writes R[SA]+imm, SBI 0x0A writes R[SA]-imm and LDI 0x0E writes imm, each into R[DR]. Results wrap modulo 2^16.
- R6: LD 0x0B drives `dmem_addr_o` with R[SA] and writes the data returned in the same cycle into R[DR].
- R7: ST 0x0C drives `dmem_addr_o` with R[SA] and `dmem_wdata_o` with R[SB]. It raises `dmem_we_o` only during that instruction's cycle and writes no register, whatever its DR field holds.
- R8: BRZ 0x0D loads PC + sext({DR,SB}) when R[SA] is zero. The 6-bit offset is two's complement, so branches can go forward or backward relative to the branch's own address.
- R9: A BRZ whose R[SA] is non-zero advances the PC by one and changes no register.
- R10: Opcodes 0x0F to 0x7F write no register and no memory, and advance the PC by one.
- R11: `imem_addr_o` always equals `pc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | PC_W | Instruction memory word address |
| imem_data_i | input | 16 | Instruction word at `imem_addr_o` |
| dmem_addr_o | output | DATA_W | Data memory word address |
| dmem_wdata_o | output | DATA_W | Store data |
| dmem_rdata_i | input | DATA_W | Asynchronous load data |
| dmem_we_o | output | 1 | Data memory write strobe |
| pc_o | output | PC_W | Current program counter |

## Verification
The bench builds the processor with its default values, DATA_W = 16 and PC_W = 16, and maps only the low six address bits onto 64-word arrays. At these widths a result can wrap past 0xFFFF and a 6-bit branch offset can step backwards out of a loop, so the two's-complement corner cases of SUB, SBI and the negative branch are all exercised. Register contents are observed only through the stores the programs make and through the PC.

// File: rtl/sc16_pkg.sv
package sc16_pkg;

  localparam int ILEN    = 16;
  localparam int OPC_W   = 7;
  localparam int RIDX_W  = 3;
  localparam int IMM_W   = 3;
  localparam int BOFF_W  = 2 * RIDX_W;

  typedef enum logic [OPC_W-1:0] {
    OP_MOV = 7'h00,
    OP_ADD = 7'h01,
    OP_SUB = 7'h02,
    OP_AND = 7'h03,
    OP_OR  = 7'h04,
    OP_XOR = 7'h05,
    OP_NOT = 7'h06,
    OP_SHL = 7'h07,
    OP_SHR = 7'h08,
    OP_ADI = 7'h09,
    OP_SBI = 7'h0A,
    OP_LD  = 7'h0B,
    OP_ST  = 7'h0C,
    OP_BRZ = 7'h0D,
    OP_LDI = 7'h0E
  } opcode_e;

  typedef enum logic [3:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_XOR,
    ALU_NOT,
    ALU_PASS_A,
    ALU_PASS_B,
    ALU_SHL,
    ALU_SHR
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    dmem_we;
    logic    branch;
    logic    use_imm;
    logic    wb_mem;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc16_decode.sv
module sc16_decode
  import sc16_pkg::*;
(
  input  logic [ILEN-1:0]   instr_i,
  output ctrl_t             ctrl_o,
  output logic [RIDX_W-1:0] dr_o,
  output logic [RIDX_W-1:0] sa_o,
  output logic [RIDX_W-1:0] sb_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [BOFF_W-1:0] boff_o
);

  logic [OPC_W-1:0] opc;

  // register fields are plain wiring
  assign opc    = instr_i[ILEN-1 -: OPC_W];
  assign dr_o   = instr_i[3*RIDX_W-1 -: RIDX_W];
  assign sa_o   = instr_i[2*RIDX_W-1 -: RIDX_W];
  assign sb_o   = instr_i[RIDX_W-1:0];
  assign imm_o  = instr_i[IMM_W-1:0];
  assign boff_o = {dr_o, sb_o};

  always_comb begin
    ctrl_o = '{rf_we: 1'b0, dmem_we: 1'b0, branch: 1'b0,
               use_imm: 1'b0, wb_mem: 1'b0, alu_op: ALU_PASS_A};
    case (opc)
      OP_MOV: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_PASS_A; end
      OP_ADD: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_ADD;    end
      OP_SUB: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_SUB;    end
      OP_AND: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_AND;    end
      OP_OR:  begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_OR;     end
      OP_XOR: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_XOR;    end
      OP_NOT: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_NOT;    end
      OP_SHL: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_SHL;    end
      OP_SHR: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_SHR;    end
      OP_ADI: begin
        ctrl_o.rf_we = 1'b1; ctrl_o.use_imm = 1'b1; ctrl_o.alu_op = ALU_ADD;
      end
      OP_SBI: begin
        ctrl_o.rf_we = 1'b1; ctrl_o.use_imm = 1'b1; ctrl_o.alu_op = ALU_SUB;
      end
      OP_LDI: begin
        ctrl_o.rf_we = 1'b1; ctrl_o.use_imm = 1'b1; ctrl_o.alu_op = ALU_PASS_B;
      end
      OP_LD:  begin ctrl_o.rf_we = 1'b1; ctrl_o.wb_mem = 1'b1;       end
      OP_ST:  ctrl_o.dmem_we = 1'b1;
      OP_BRZ: ctrl_o.branch  = 1'b1;
      default: ;
    endcase
  end

  // R7, R10: at most one kind of side effect per instruction
  always_comb begin
    if (!$isunknown(instr_i)) begin
      p_one_effect_r7: assert ($onehot0({ctrl_o.rf_we, ctrl_o.dmem_we, ctrl_o.branch}));
    end
  end

endmodule

// File: rtl/sc16_alu.sv
module sc16_alu
  import sc16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o
);

  always_comb begin
    case (op_i)
      ALU_ADD:    y_o = a_i + b_i;
      ALU_SUB:    y_o = a_i - b_i;
      ALU_AND:    y_o = a_i & b_i;
      ALU_OR:     y_o = a_i | b_i;
      ALU_XOR:    y_o = a_i ^ b_i;
      ALU_NOT:    y_o = ~a_i;
      ALU_PASS_B: y_o = b_i;
      ALU_SHL:    y_o = {a_i[W-2:0], 1'b0};
      ALU_SHR:    y_o = {1'b0, a_i[W-1:1]};
      default:    y_o = a_i;
    endcase
  end

endmodule

// File: rtl/sc16_regfile.sv
module sc16_regfile #(
  parameter int W = 16,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i
);

  logic [N-1:0][W-1:0] rf_q;

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            rf_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))     rf_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = rf_q[raddr_a_i];
  assign rdata_b_o = rf_q[raddr_b_i];

  // R10: no write enable, no register change
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rf_q));

  // R3: enabled write lands in the addressed register
  p_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rf_q[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/sc16_cpu.sv
module sc16_cpu
  import sc16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 16,
  parameter int NREG   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PC_W-1:0]   imem_addr_o,
  input  logic [ILEN-1:0]   imem_data_i,
  output logic [DATA_W-1:0] dmem_addr_o,
  output logic [DATA_W-1:0] dmem_wdata_o,
  input  logic [DATA_W-1:0] dmem_rdata_i,
  output logic              dmem_we_o,
  output logic [PC_W-1:0]   pc_o
);

  localparam int RA_W = $clog2(NREG);

  logic [PC_W-1:0]   pc_q, pc_d, br_target;
  ctrl_t             ctrl;
  logic [RIDX_W-1:0] dr, sa, sb;
  logic [IMM_W-1:0]  imm;
  logic [BOFF_W-1:0] boff;
  logic [DATA_W-1:0] rs_a, rs_b, alu_b, alu_y, wb_data;
  logic              br_taken;

  sc16_decode u_dec (
    .instr_i (imem_data_i),
    .ctrl_o  (ctrl),
    .dr_o    (dr),
    .sa_o    (sa),
    .sb_o    (sb),
    .imm_o   (imm),
    .boff_o  (boff)
  );

  sc16_regfile #(.W(DATA_W), .N(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raddr_a_i (RA_W'(sa)),
    .raddr_b_i (RA_W'(sb)),
    .rdata_a_o (rs_a),
    .rdata_b_o (rs_b),
    .we_i      (ctrl.rf_we),
    .waddr_i   (RA_W'(dr)),
    .wdata_i   (wb_data)
  );

  assign alu_b = ctrl.use_imm ? {{(DATA_W-IMM_W){1'b0}}, imm} : rs_b;

  sc16_alu #(.W(DATA_W)) u_alu (
    .a_i  (rs_a),
    .b_i  (alu_b),
    .op_i (ctrl.alu_op),
    .y_o  (alu_y)
  );

  assign wb_data = ctrl.wb_mem ? dmem_rdata_i : alu_y;

  assign br_taken  = ctrl.branch && (rs_a == '0);
  assign br_target = pc_q + {{(PC_W-BOFF_W){boff[BOFF_W-1]}}, boff};
  assign pc_d      = br_taken ? br_target : pc_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign imem_addr_o  = pc_q;
  assign pc_o         = pc_q;
  assign dmem_addr_o  = rs_a;
  assign dmem_wdata_o = rs_b;
  assign dmem_we_o    = ctrl.dmem_we;

  // R2: sequential step
  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_taken |=> pc_q == $past(pc_q) + 1'b1);

  // R8: taken branch lands on pc + signed offset
  p_br_target_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken |=> pc_q == $past(pc_q) + $past({{(PC_W-BOFF_W){imem_data_i[8]}}, imem_data_i[8:6], imem_data_i[2:0]}));

  // R7: store never writes the register file
  p_store_no_wb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> !ctrl.rf_we);

endmodule

// File: tb/sc16_cpu_tb.sv
module sc16_cpu_tb;
  import sc16_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata, pc;
  logic        dmem_we;

  logic [15:0] imem [64];
  logic [15:0] dmem [64];
  logic [15:0] dmem_init [64];
  int          we_cnt;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc16_cpu u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .imem_addr_o  (imem_addr),
    .imem_data_i  (imem_data),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .dmem_rdata_i (dmem_rdata),
    .dmem_we_o    (dmem_we),
    .pc_o         (pc)
  );

  assign imem_data  = imem[imem_addr[5:0]];
  assign dmem_rdata = dmem[dmem_addr[5:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) dmem[i] <= dmem_init[i];
      we_cnt <= 0;
    end else if (dmem_we) begin
      dmem[dmem_addr[5:0]] <= dmem_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  function automatic logic [15:0] enc(input logic [6:0] op, input logic [2:0] d,
                                      input logic [2:0] a, input logic [2:0] b);
    return {op, d, a, b};
  endfunction

  function automatic logic [15:0] brz(input logic [2:0] a, input logic [5:0] off);
    return {OP_BRZ, off[5:3], a, off[2:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < 64; i++) begin
      imem[i]      = brz(3'd0, 6'd0);
      dmem_init[i] = 16'h0000;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_all();
    for (int i = 0; i < 5; i++) imem[i] = enc(OP_ADI, 3'd1, 3'd1, 3'd1);
    imem[5] = enc(OP_ST, 3'd0, 3'd0, 3'd1);
    imem[6] = brz(3'd0, 6'd0);
    do_reset();
    cycles(3);
    rst_n = 1'b0;
    #1;
    chk(pc == 16'd0, "R1 pc in reset", pc, 16'd0);
    chk(imem_addr == 16'd0, "R11 imem addr in reset", imem_addr, 16'd0);
    do_reset();
    cycles(10);
    chk(dmem[0] == 16'd5, "R1 registers cleared", dmem[0], 16'd5);
  endtask

  task automatic t_rr_ops();
    clear_all();
    imem[0]  = enc(OP_LDI, 3'd1, 3'd0, 3'd6);
    imem[1]  = enc(OP_SHL, 3'd1, 3'd1, 3'd0);
    imem[2]  = enc(OP_SHL, 3'd1, 3'd1, 3'd0);
    imem[3]  = enc(OP_ADI, 3'd1, 3'd1, 3'd5);
    imem[4]  = enc(OP_LDI, 3'd2, 3'd0, 3'd3);
    imem[5]  = enc(OP_ADD, 3'd3, 3'd1, 3'd2);
    imem[6]  = enc(OP_SUB, 3'd4, 3'd2, 3'd1);
    imem[7]  = enc(OP_AND, 3'd5, 3'd1, 3'd2);
    imem[8]  = enc(OP_OR,  3'd6, 3'd1, 3'd2);
    imem[9]  = enc(OP_ST,  3'd0, 3'd7, 3'd3);
    imem[10] = enc(OP_ADI, 3'd7, 3'd7, 3'd1);
    imem[11] = enc(OP_ST,  3'd0, 3'd7, 3'd4);
    imem[12] = enc(OP_ADI, 3'd7, 3'd7, 3'd1);
    imem[13] = enc(OP_ST,  3'd0, 3'd7, 3'd5);
    imem[14] = enc(OP_ADI, 3'd7, 3'd7, 3'd1);
    imem[15] = enc(OP_ST,  3'd0, 3'd7, 3'd6);
    imem[16] = enc(OP_XOR, 3'd3, 3'd1, 3'd2);
    imem[17] = enc(OP_ADI, 3'd7, 3'd7, 3'd1);
    imem[18] = enc(OP_ST,  3'd0, 3'd7, 3'd3);
    do_reset();
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk(pc == 16'(k), "R2 pc step", pc, 16'(k));
    end
    cycles(25);
    chk(dmem[0] == 16'd32,   "R3 add", dmem[0], 16'd32);
    chk(dmem[1] == 16'hFFE6, "R3 sub wrap", dmem[1], 16'hFFE6);
    chk(dmem[2] == 16'd1,    "R3 and", dmem[2], 16'd1);
    chk(dmem[3] == 16'd31,   "R3 or", dmem[3], 16'd31);
    chk(dmem[4] == 16'd30,   "R3 xor", dmem[4], 16'd30);
    chk(pc == 16'd19,        "R8 halt loop", pc, 16'd19);
  endtask

  task automatic t_unary();
    clear_all();
    imem[0] = enc(OP_LDI, 3'd1, 3'd0, 3'd5);
    imem[1] = enc(OP_NOT, 3'd2, 3'd1, 3'd0);
    imem[2] = enc(OP_SHR, 3'd3, 3'd2, 3'd0);
    imem[3] = enc(OP_MOV, 3'd4, 3'd2, 3'd0);
    imem[4] = enc(OP_SHL, 3'd5, 3'd2, 3'd0);
    imem[5] = enc(OP_ST,  3'd0, 3'd7, 3'd2);
    imem[6] = enc(OP_ADI, 3'd7, 3'd7, 3'd1);
    imem[7] = enc(OP_ST,  3'd0, 3'd7, 3'd3);
    imem[8] = enc(OP_ADI, 3'd7, 3'd7, 3'd1);
    imem[9] = enc(OP_ST,  3'd0, 3'd7, 3'd4);
    imem[10] = enc(OP_ADI, 3'd7, 3'd7, 3'd1);
    imem[11] = enc(OP_ST,  3'd0, 3'd7, 3'd5);
    do_reset();
    cycles(20);
    chk(dmem[0] == 16'hFFFA, "R4 not", dmem[0], 16'hFFFA);
    chk(dmem[1] == 16'h7FFD, "R4 shr zero fill", dmem[1], 16'h7FFD);
    chk(dmem[2] == 16'hFFFA, "R4 mov", dmem[2], 16'hFFFA);
    chk(dmem[3] == 16'hFFF4, "R4 shl", dmem[3], 16'hFFF4);
  endtask

  task automatic t_imm();
    clear_all();
    imem[0] = enc(OP_LDI, 3'd1, 3'd0, 3'd7);
    imem[1] = enc(OP_ADI, 3'd2, 3'd1, 3'd7);
    imem[2] = enc(OP_SBI, 3'd3, 3'd0, 3'd1);
    imem[3] = enc(OP_SBI, 3'd4, 3'd2, 3'd7);
    imem[4] = enc(OP_ST,  3'd0, 3'd7, 3'd1);
    imem[5] = enc(OP_ADI, 3'd7, 3'd7, 3'd1);
    imem[6] = enc(OP_ST,  3'd0, 3'd7, 3'd2);
    imem[7] = enc(OP_ADI, 3'd7, 3'd7, 3'd1);
    imem[8] = enc(OP_ST,  3'd0, 3'd7, 3'd3);
    imem[9] = enc(OP_ADI, 3'd7, 3'd7, 3'd1);
    imem[10] = enc(OP_ST, 3'd0, 3'd7, 3'd4);
    do_reset();
    cycles(16);
    chk(dmem[0] == 16'd7,    "R5 ldi", dmem[0], 16'd7);
    chk(dmem[1] == 16'd14,   "R5 adi", dmem[1], 16'd14);
    chk(dmem[2] == 16'hFFFF, "R5 sbi wrap", dmem[2], 16'hFFFF);
    chk(dmem[3] == 16'd7,    "R5 sbi", dmem[3], 16'd7);
  endtask

  task automatic t_load();
    clear_all();
    dmem_init[10] = 16'hBEEF;
    dmem_init[3]  = 16'h1234;
    imem[0] = enc(OP_LDI, 3'd1, 3'd0, 3'd5);
    imem[1] = enc(OP_ADI, 3'd1, 3'd1, 3'd5);
    imem[2] = enc(OP_LD,  3'd2, 3'd1, 3'd0);
    imem[3] = enc(OP_LDI, 3'd3, 3'd0, 3'd3);
    imem[4] = enc(OP_LD,  3'd4, 3'd3, 3'd0);
    imem[5] = enc(OP_ADD, 3'd5, 3'd2, 3'd4);
    imem[6] = enc(OP_ST,  3'd0, 3'd0, 3'd5);
    imem[7] = enc(OP_LDI, 3'd6, 3'd0, 3'd1);
    imem[8] = enc(OP_ST,  3'd0, 3'd6, 3'd2);
    do_reset();
    cycles(2);
    chk(dmem_addr == 16'd10, "R6 load address", dmem_addr, 16'd10);
    cycles(12);
    chk(dmem[0] == 16'hD123, "R6 load sum", dmem[0], 16'hD123);
    chk(dmem[1] == 16'hBEEF, "R6 load value", dmem[1], 16'hBEEF);
  endtask

  task automatic t_store();
    clear_all();
    dmem_init[0] = 16'hFFFF;
    imem[0] = enc(OP_LDI, 3'd1, 3'd0, 3'd2);
    imem[1] = enc(OP_LDI, 3'd2, 3'd0, 3'd7);
    imem[2] = enc(OP_ST,  3'd3, 3'd1, 3'd2);
    imem[3] = enc(OP_ST,  3'd0, 3'd0, 3'd3);
    do_reset();
    cycles(1);
    chk(dmem_we == 1'b0, "R7 strobe low off-store", 16'(dmem_we), 16'd0);
    cycles(1);
    chk(dmem_we == 1'b1, "R7 strobe on store", 16'(dmem_we), 16'd1);
    chk(dmem_addr == 16'd2, "R7 store address", dmem_addr, 16'd2);
    chk(dmem_wdata == 16'd7, "R7 store data", dmem_wdata, 16'd7);
    cycles(8);
    chk(dmem[2] == 16'd7, "R7 stored", dmem[2], 16'd7);
    chk(dmem[0] == 16'd0, "R7 dr untouched", dmem[0], 16'd0);
    chk(we_cnt == 2, "R7 strobe count", 16'(we_cnt), 16'd2);
  endtask

  task automatic t_branch();
    clear_all();
    imem[0]  = enc(OP_LDI, 3'd1, 3'd0, 3'd1);
    imem[1]  = brz(3'd1, 6'd3);
    imem[2]  = enc(OP_ADI, 3'd2, 3'd2, 3'd1);
    imem[3]  = brz(3'd0, 6'd2);
    imem[4]  = enc(OP_LDI, 3'd2, 3'd0, 3'd7);
    imem[5]  = enc(OP_LDI, 3'd4, 3'd0, 3'd3);
    imem[6]  = enc(OP_ADI, 3'd3, 3'd3, 3'd2);
    imem[7]  = enc(OP_SBI, 3'd4, 3'd4, 3'd1);
    imem[8]  = brz(3'd4, 6'd2);
    imem[9]  = brz(3'd0, 6'b111101);
    imem[10] = enc(OP_ST,  3'd0, 3'd0, 3'd2);
    imem[11] = enc(OP_LDI, 3'd5, 3'd0, 3'd1);
    imem[12] = enc(OP_ST,  3'd0, 3'd5, 3'd3);
    do_reset();
    cycles(2);
    chk(pc == 16'd2, "R9 not taken", pc, 16'd2);
    cycles(2);
    chk(pc == 16'd5, "R8 forward taken", pc, 16'd5);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(imem_addr == pc, "R11 imem addr tracks pc", imem_addr, pc);
    end
    chk(dmem[0] == 16'd1, "R9 no reg change", dmem[0], 16'd1);
    chk(dmem[1] == 16'd6, "R8 backward loop", dmem[1], 16'd6);
    chk(pc == 16'd13, "R8 final pc", pc, 16'd13);
  endtask

  task automatic t_undef();
    clear_all();
    dmem_init[5] = 16'hAAAA;
    imem[0] = enc(OP_LDI, 3'd1, 3'd0, 3'd5);
    imem[1] = enc(7'h7F, 3'd1, 3'd1, 3'd1);
    imem[2] = enc(7'h10, 3'd1, 3'd1, 3'd1);
    imem[3] = enc(OP_ST, 3'd0, 3'd0, 3'd1);
    do_reset();
    cycles(2);
    chk(pc == 16'd2, "R10 pc step", pc, 16'd2);
    cycles(6);
    chk(dmem[0] == 16'd5, "R10 no reg write", dmem[0], 16'd5);
    chk(dmem[5] == 16'hAAAA, "R10 no mem write", dmem[5], 16'hAAAA);
    chk(we_cnt == 1, "R10 strobe count", 16'(we_cnt), 16'd1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    clear_all();
    t_reset();
    t_rr_ops();
    t_unary();
    t_imm();
    t_load();
    t_store();
    t_branch();
    t_undef();
    finish_run();
  end

endmodule